// File: doc/BRIEF.md
# Bit-Granular Frame Packer and Serializer

This block lets a byte-wide FIFO carry frames whose length is not a whole number of bytes. On the receive side it collects single bits from a serial line and packs them into bytes for the FIFO. The first bit can be placed at any bit position of the first byte. A frame that ends part-way through a byte still flushes that byte, and the block reports how many low bit positions of the final byte hold data. On the transmit side it pops FIFO bytes and sends them one bit per strobe, least significant bit first. The final byte of the frame can be cut short to a programmed number of bits.

A single framing control register holds both settings: the receive start offset and the transmit final-byte length. Each engine takes a copy of its field when a frame starts. When that frame ends, the field is cleared to zero, unless software wrote the register while the frame was running. In that case the written value is kept for the next frame. Modulation, CRC and the FIFO storage itself are outside this block.

Top module: `bitframe_serdes`

## Requirements
- R1: Out of reset the control register reads 00h, and no receive push, transmit bit or FIFO pop is issued.
- R2: The control register answers only at address 0Fh. Receive offset is bits 6:4 and transmit final-byte length is bits 2:0. Bits 7 and 3 always read 0. A read of any other address returns 00h, and a write to any other address changes nothing.
- R3: The first received bit of a frame is stored at the bit position given by the receive offset captured at frame start. All lower positions of that first byte read 0.
- R4: Each further received bit goes to the next higher bit position. After position 7 it wraps to position 0 of a new byte. A byte whose position 7 is filled is pushed, with the partial-byte marker low, in the cycle after that bit is taken.
- R5: In the cycle after end of receive frame, a done pulse reports a valid-bit count. If the final byte is partial, it is pushed in that same cycle with the partial-byte marker high, and the count is the number of its low positions holding data (1 to 7). Otherwise no byte is pushed, and the count is 8 if any bit arrived or 0 if none did.
- R6: The receive offset field clears to 000 once the receive done pulse has occurred, unless the register was written during that frame.
- R7: Transmit bytes go out least significant bit first, one bit per cycle in which the line strobe is high. A FIFO pop happens in exactly the cycle that sends the first bit of each byte.
- R8: The byte that is flagged as last when it is popped sends only as many bits as the captured final-byte length, where 000 means all 8. A transmit done pulse follows one cycle after the last bit.
- R9: The transmit final-byte length field clears to 000 once the transmit done pulse has occurred, unless the register was written during that frame.
- R10: A register write made while a frame is in progress does not change that frame. It is used from the next start of frame.
- R11: No transmit bit is issued while the line strobe is low, or while a byte is needed and the FIFO reports no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_start | input | 1 | Receive start-of-frame pulse |
| rx_end | input | 1 | Receive end-of-frame pulse |
| rx_bit_vld | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received bit value |
| rx_push | output | 1 | Push a packed byte into the FIFO |
| rx_byte | output | 8 | Packed byte |
| rx_last | output | 1 | Pushed byte is a partial final byte |
| rx_done | output | 1 | Receive frame finished |
| rx_done_bits | output | 4 | Valid-bit count of the final byte |
| tx_start | input | 1 | Transmit start-of-frame pulse |
| tx_ready | input | 1 | Line accepts a bit this cycle |
| tx_bit_vld | output | 1 | A transmit bit is issued this cycle |
| tx_bit | output | 1 | Transmit bit value |
| tx_done | output | 1 | Transmit frame finished |
| tx_pop | output | 1 | Pop the FIFO head byte |
| tx_avail | input | 1 | FIFO head byte is valid |
| tx_head_last | input | 1 | FIFO head byte is the frame's last |
| tx_byte | input | 8 | FIFO head byte |

## Verification
The assertions assume these things about the inputs. `rx_end` never coincides with `rx_bit_vld`. No start pulse arrives while the same direction is still busy. While `tx_avail` is high, `tx_byte` and `tx_head_last` describe the head byte, and exactly one byte of each transmit frame is flagged last. The bench meets these assumptions by building each frame in one task. The task sends start, bits and end in strict order, and it advances its model FIFO index only after a sampled pop. Random gaps in the bit strobes, the line strobe and the FIFO availability are added only inside those limits.

// File: rtl/bitframe_pkg.sv
package bitframe_pkg;
   // default byte width of the FIFO side
   localparam int unsigned BF_DEF_DATA_W = 8;

   // control register holds two position fields, each followed by a reserved bit
   function automatic int unsigned bf_reg_width(input int unsigned pos_w);
      return 2 * pos_w + 2;
   endfunction
endpackage

// File: rtl/bitframe_cfg.sv
module bitframe_cfg #(
   parameter int unsigned POS_W = 3,
   parameter int unsigned ADDR_W = 4,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 'hF,
   parameter int unsigned REG_W = 2 * POS_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              rx_busy,
   input  logic              rx_done,
   input  logic              tx_busy,
   input  logic              tx_done,
   output logic [POS_W-1:0]  rx_offset,
   output logic [POS_W-1:0]  tx_lastlen
);
   localparam int unsigned TX_LO = 0;
   localparam int unsigned RX_LO = POS_W + 1;

   generate
      if (REG_W != 2 * POS_W + 2) begin : g_bad_reg_w
         $error("bitframe_cfg: REG_W must equal 2*POS_W+2");
      end
   endgenerate

   logic             sel;
   logic             wr;
   logic [POS_W-1:0] rx_f_q;
   logic [POS_W-1:0] tx_f_q;
   logic             rx_dirty_q;
   logic             tx_dirty_q;

   assign sel = (reg_addr == CFG_ADDR);
   assign wr  = reg_we && sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_f_q     <= '0;
         tx_f_q     <= '0;
         rx_dirty_q <= 1'b0;
         tx_dirty_q <= 1'b0;
      end else begin
         if (wr) begin
            rx_f_q <= reg_wdata[RX_LO +: POS_W];
            tx_f_q <= reg_wdata[TX_LO +: POS_W];
         end else begin
            if (rx_done && !rx_dirty_q) rx_f_q <= '0;
            if (tx_done && !tx_dirty_q) tx_f_q <= '0;
         end
         if (wr && rx_busy)  rx_dirty_q <= 1'b1;
         else if (rx_done)   rx_dirty_q <= 1'b0;
         if (wr && tx_busy)  tx_dirty_q <= 1'b1;
         else if (tx_done)   tx_dirty_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (sel) begin
         reg_rdata[RX_LO +: POS_W] = rx_f_q;
         reg_rdata[TX_LO +: POS_W] = tx_f_q;
      end
   end

   assign rx_offset  = rx_f_q;
   assign tx_lastlen = tx_f_q;

   // R6
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !wr && !rx_dirty_q) |=> (rx_offset == '0));
   // R9
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !wr && !tx_dirty_q) |=> (tx_lastlen == '0));
endmodule

// File: rtl/bitframe_rx.sv
module bitframe_rx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned POS_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_start,
   input  logic              rx_end,
   input  logic              rx_bit_vld,
   input  logic              rx_bit,
   input  logic [POS_W-1:0]  offset_cfg,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_last,
   output logic              rx_done,
   output logic [POS_W:0]    rx_done_bits,
   output logic              busy
);
   localparam logic [POS_W-1:0] POS_TOP  = POS_W'(DATA_W - 1);
   localparam logic [POS_W:0]   LEN_FULL = (POS_W + 1)'(DATA_W);

   logic              busy_q;
   logic [POS_W-1:0]  pos_q;
   logic [DATA_W-1:0] acc_q;
   logic              cur_any_q;
   logic              any_q;
   logic [DATA_W-1:0] merged;

   assign merged = acc_q | (DATA_W'(rx_bit) << pos_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         pos_q        <= '0;
         acc_q        <= '0;
         cur_any_q    <= 1'b0;
         any_q        <= 1'b0;
         rx_push      <= 1'b0;
         rx_byte      <= '0;
         rx_last      <= 1'b0;
         rx_done      <= 1'b0;
         rx_done_bits <= '0;
      end else begin
         rx_push <= 1'b0;
         rx_last <= 1'b0;
         rx_done <= 1'b0;
         if (rx_start) begin
            busy_q    <= 1'b1;
            pos_q     <= offset_cfg;
            acc_q     <= '0;
            cur_any_q <= 1'b0;
            any_q     <= 1'b0;
         end else if (busy_q) begin
            if (rx_end) begin
               busy_q       <= 1'b0;
               rx_done      <= 1'b1;
               rx_done_bits <= cur_any_q ? {1'b0, pos_q} : (any_q ? LEN_FULL : '0);
               if (cur_any_q) begin
                  rx_push <= 1'b1;
                  rx_last <= 1'b1;
                  rx_byte <= acc_q;
               end
            end else if (rx_bit_vld) begin
               any_q <= 1'b1;
               if (pos_q == POS_TOP) begin
                  rx_push   <= 1'b1;
                  rx_byte   <= merged;
                  acc_q     <= '0;
                  cur_any_q <= 1'b0;
                  pos_q     <= '0;
               end else begin
                  acc_q     <= merged;
                  cur_any_q <= 1'b1;
                  pos_q     <= pos_q + 1'b1;
               end
            end
         end
      end
   end

   assign busy = busy_q;

   // R5
   rx_last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_last |-> rx_done);
   // R5
   rx_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> (rx_done_bits <= LEN_FULL));
   // R5
   rx_partial_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_last |-> (rx_done_bits != '0 && rx_done_bits != LEN_FULL));
endmodule

// File: rtl/bitframe_tx.sv
module bitframe_tx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned POS_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_start,
   input  logic [POS_W-1:0]  lastlen_cfg,
   input  logic              tx_ready,
   input  logic              tx_avail,
   input  logic              tx_head_last,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              tx_bit_vld,
   output logic              tx_bit,
   output logic              tx_pop,
   output logic              tx_done,
   output logic              busy
);
   localparam logic [POS_W:0] LEN_FULL = (POS_W + 1)'(DATA_W);

   logic              busy_q;
   logic [DATA_W-1:0] sh_q;
   logic [POS_W-1:0]  rem_q;
   logic [POS_W-1:0]  len_q;
   logic              fin_q;
   logic              done_q;
   logic              need;
   logic              fire;
   logic              ending;
   logic [POS_W:0]    first_len;
   logic [POS_W:0]    len_m1;

   always_comb begin
      need      = busy_q && (rem_q == '0);
      first_len = (tx_head_last && len_q != '0) ? {1'b0, len_q} : LEN_FULL;
      len_m1    = first_len - 1'b1;
      fire      = busy_q && tx_ready && (!need || tx_avail);
      if (need) ending = fire && tx_head_last && (len_m1 == '0);
      else      ending = fire && fin_q && (rem_q == POS_W'(1));
   end

   assign tx_bit_vld = fire;
   assign tx_pop     = fire && need;
   assign tx_bit     = need ? tx_byte[0] : sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh_q   <= '0;
         rem_q  <= '0;
         len_q  <= '0;
         fin_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= ending;
         if (tx_start) begin
            busy_q <= 1'b1;
            len_q  <= lastlen_cfg;
            rem_q  <= '0;
            fin_q  <= 1'b0;
         end else if (fire) begin
            if (need) begin
               sh_q  <= tx_byte >> 1;
               rem_q <= len_m1[POS_W-1:0];
               fin_q <= tx_head_last;
            end else begin
               sh_q  <= sh_q >> 1;
               rem_q <= rem_q - 1'b1;
            end
            if (ending) busy_q <= 1'b0;
         end
      end
   end

   assign tx_done = done_q;
   assign busy    = busy_q;

   // R7
   tx_pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> (tx_avail && tx_bit_vld));
   // R11
   tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bit_vld |-> tx_ready);
   // R8
   tx_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> !tx_bit_vld);
endmodule

// File: rtl/bitframe_serdes.sv
module bitframe_serdes #(
   parameter int unsigned DATA_W = bitframe_pkg::BF_DEF_DATA_W,
   parameter int unsigned ADDR_W = 4,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 'hF,
   localparam int unsigned POS_W = $clog2(DATA_W),
   localparam int unsigned REG_W = bitframe_pkg::bf_reg_width(POS_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              rx_start,
   input  logic              rx_end,
   input  logic              rx_bit_vld,
   input  logic              rx_bit,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_last,
   output logic              rx_done,
   output logic [POS_W:0]    rx_done_bits,
   input  logic              tx_start,
   input  logic              tx_ready,
   output logic              tx_bit_vld,
   output logic              tx_bit,
   output logic              tx_done,
   output logic              tx_pop,
   input  logic              tx_avail,
   input  logic              tx_head_last,
   input  logic [DATA_W-1:0] tx_byte
);
   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("bitframe_serdes: DATA_W must be a power of two of at least 2");
      end
   endgenerate

   logic [POS_W-1:0] rx_offset;
   logic [POS_W-1:0] tx_lastlen;
   logic             rx_busy;
   logic             tx_busy;

   bitframe_cfg #(
      .POS_W(POS_W), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .REG_W(REG_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_busy(rx_busy), .rx_done(rx_done), .tx_busy(tx_busy), .tx_done(tx_done),
      .rx_offset(rx_offset), .tx_lastlen(tx_lastlen)
   );

   bitframe_rx #(.DATA_W(DATA_W), .POS_W(POS_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .rx_start(rx_start), .rx_end(rx_end), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
      .offset_cfg(rx_offset),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_last(rx_last),
      .rx_done(rx_done), .rx_done_bits(rx_done_bits), .busy(rx_busy)
   );

   bitframe_tx #(.DATA_W(DATA_W), .POS_W(POS_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .tx_start(tx_start), .lastlen_cfg(tx_lastlen), .tx_ready(tx_ready),
      .tx_avail(tx_avail), .tx_head_last(tx_head_last), .tx_byte(tx_byte),
      .tx_bit_vld(tx_bit_vld), .tx_bit(tx_bit), .tx_pop(tx_pop),
      .tx_done(tx_done), .busy(tx_busy)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> (!tx_bit_vld && !tx_pop));
endmodule

// File: tb/bitframe_serdes_test.sv
module bitframe_serdes_test;
   localparam logic [3:0] CFG = 4'hF;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = CFG;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       rx_start = 0, rx_end = 0, rx_bit_vld = 0, rx_bit = 0;
   logic       rx_push, rx_last, rx_done;
   logic [7:0] rx_byte;
   logic [3:0] rx_done_bits;
   logic       tx_start = 0, tx_ready = 0;
   logic       tx_bit_vld, tx_bit, tx_done, tx_pop;
   logic       tx_avail, tx_head_last;
   logic [7:0] tx_byte;

   logic [7:0] tx_mem [0:7];
   int         tx_rd = 0;
   int         tx_n = 0;
   logic       tx_gate = 1'b1;

   assign tx_avail     = tx_gate && (tx_rd < tx_n);
   assign tx_byte      = tx_mem[tx_rd[2:0]];
   assign tx_head_last = (tx_rd == tx_n - 1);

   bitframe_serdes uut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_start(rx_start), .rx_end(rx_end), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_last(rx_last),
      .rx_done(rx_done), .rx_done_bits(rx_done_bits),
      .tx_start(tx_start), .tx_ready(tx_ready), .tx_bit_vld(tx_bit_vld), .tx_bit(tx_bit),
      .tx_done(tx_done), .tx_pop(tx_pop), .tx_avail(tx_avail),
      .tx_head_last(tx_head_last), .tx_byte(tx_byte)
   );

   int n_tests = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // receive log, filled only by rx_tick
   logic [7:0] lg_b [0:15];
   bit         lg_l [0:15];
   int         lg_n;
   bit         dn_seen;
   int         dn_bits;

   task automatic rx_tick();
      @(negedge clk);
      #1;
      if (rx_push && lg_n < 16) begin
         lg_b[lg_n] = rx_byte;
         lg_l[lg_n] = rx_last;
         lg_n++;
      end
      if (rx_done) begin
         dn_seen = 1;
         dn_bits = int'(rx_done_bits);
      end
   endtask

   task automatic write_cfg(input logic [3:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      #1;
      reg_we   = 1'b0;
      reg_addr = CFG;
   endtask

   task automatic rx_frame(input int off, input int nb, input logic [63:0] bits,
                           input int mid_at, input logic [7:0] mid_val,
                           input int exp_after, input string tag);
      int p = off;
      logic [7:0] cur = '0;
      bit any = 0;
      int en = 0;
      int edone;
      int mism = 0;
      int lmism = 0;
      logic [7:0] eb [0:15];
      bit el [0:15];
      write_cfg(CFG, {1'b0, 3'(off), 4'b0});
      lg_n = 0;
      dn_seen = 0;
      dn_bits = -1;
      rx_start = 1;
      rx_tick();
      rx_start = 0;
      for (int i = 0; i < nb; i++) begin
         if (i == mid_at) begin
            reg_wdata = mid_val;
            reg_we = 1;
            rx_tick();
            reg_we = 0;
         end
         while ($urandom % 3 == 0) rx_tick();
         rx_bit_vld = 1;
         rx_bit = bits[i];
         rx_tick();
         rx_bit_vld = 0;
      end
      rx_end = 1;
      rx_tick();
      rx_end = 0;
      rx_tick();
      rx_tick();
      // expected packing per R3/R4/R5
      for (int i = 0; i < nb; i++) begin
         cur[p] = bits[i];
         any = 1;
         if (p == 7) begin
            eb[en] = cur; el[en] = 0; en++;
            cur = '0; any = 0; p = 0;
         end else p++;
      end
      if (any) begin
         eb[en] = cur; el[en] = 1; en++;
         edone = p;
      end else edone = (nb > 0) ? 8 : 0;
      check(lg_n == en, "R4", {tag, " rx push count"}, lg_n, en);
      if (en > 0 && lg_n > 0)
         check(lg_b[0] == eb[0], "R3", {tag, " rx first byte"}, lg_b[0], eb[0]);
      for (int i = 1; i < en && i < lg_n; i++) if (lg_b[i] != eb[i]) mism++;
      for (int i = 0; i < en && i < lg_n; i++) if (lg_l[i] != el[i]) lmism++;
      check(mism == 0, "R4", {tag, " rx later bytes mismatches"}, mism, 0);
      check(lmism == 0, "R5", {tag, " rx partial marker mismatches"}, lmism, 0);
      check(dn_seen && dn_bits == edone, "R5", {tag, " rx done bit count"}, dn_bits, edone);
      check(int'(reg_rdata[6:4]) == exp_after, "R6", {tag, " rx offset after frame"},
            int'(reg_rdata[6:4]), exp_after);
   endtask

   task automatic tx_frame(input int len, input int n, input logic [63:0] data,
                           input int mid_at, input logic [7:0] mid_val,
                           input int exp_after, input string tag);
      int c = 0;
      int pops = 0;
      int bad = 0;
      int k = 0;
      int mism = 0;
      int etot;
      int ei = 0;
      bit done = 0;
      bit pop;
      logic got [0:63];
      write_cfg(CFG, {5'b0, 3'(len)});
      for (int i = 0; i < 8; i++) tx_mem[i] = data[8*i +: 8];
      tx_n = n;
      tx_rd = 0;
      tx_start = 1;
      @(negedge clk);
      #1;
      tx_start = 0;
      while (!done && k < 600) begin
         tx_ready = ($urandom % 4) != 0;
         tx_gate  = ($urandom % 5) != 0;
         if (k == mid_at) begin
            reg_wdata = mid_val;
            reg_we = 1;
         end
         #1;
         if (tx_bit_vld) begin
            if (!tx_ready) bad++;
            if (c < 64) got[c] = tx_bit;
            c++;
         end
         if (tx_pop && !tx_avail) bad++;
         pop = tx_pop;
         if (pop) pops++;
         @(posedge clk);
         #1;
         if (pop) tx_rd++;
         reg_we = 0;
         @(negedge clk);
         #1;
         if (tx_done) done = 1;
         k++;
      end
      tx_ready = 0;
      tx_gate = 1;
      @(negedge clk);
      #1;
      etot = (n - 1) * 8 + ((len == 0) ? 8 : len);
      for (int b = 0; b < n; b++) begin
         int nbits = (b == n - 1 && len != 0) ? len : 8;
         for (int j = 0; j < nbits; j++) begin
            if (ei < c && ei < 64 && got[ei] != data[8*b + j]) mism++;
            ei++;
         end
      end
      check(done, "R8", {tag, " tx done pulse"}, int'(done), 1);
      check(c == etot, "R8", {tag, " tx bit count"}, c, etot);
      check(mism == 0, "R7", {tag, " tx LSB-first bit mismatches"}, mism, 0);
      check(pops == n, "R7", {tag, " tx pop count"}, pops, n);
      check(bad == 0, "R11", {tag, " tx strobe or empty violations"}, bad, 0);
      check(int'(reg_rdata[2:0]) == exp_after, "R9", {tag, " tx length after frame"},
            int'(reg_rdata[2:0]), exp_after);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 8; i++) tx_mem[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      rst_n = 1;
      tx_ready = 1;
      #1;
      // R1 reset state
      check(reg_rdata == 8'h00, "R1", "config after reset", reg_rdata, 0);
      check(!rx_push && !tx_bit_vld && !tx_pop, "R1", "outputs idle after reset",
            {rx_push, tx_bit_vld, tx_pop}, 0);
      tx_ready = 0;

      // R2 layout, reserved bits, other addresses
      write_cfg(CFG, 8'hFF);
      #1;
      check(reg_rdata == 8'h77, "R2", "reserved bits read zero", reg_rdata, 8'h77);
      write_cfg(4'h3, 8'h00);
      #1;
      check(reg_rdata == 8'h77, "R2", "write elsewhere ignored", reg_rdata, 8'h77);
      reg_addr = 4'h3;
      #1;
      check(reg_rdata == 8'h00, "R2", "read elsewhere is zero", reg_rdata, 0);
      reg_addr = CFG;
      write_cfg(CFG, 8'h00);

      // directed receive corners
      rx_frame(7, 2, 64'h3, -1, 8'h0, 0, "R3 off7");
      rx_frame(0, 8, 64'hA5, -1, 8'h0, 0, "R4 off0 full");
      rx_frame(4, 0, 64'h0, -1, 8'h0, 0, "R5 empty");
      rx_frame(3, 8, 64'hFF, 4, 8'h50, 5, "R10 rx midwrite");
      rx_frame(5, 3, 64'h7, -1, 8'h0, 0, "R10 rx next");

      // directed transmit corners
      tx_frame(1, 1, 64'h01, -1, 8'h0, 0, "R8 single bit");
      tx_frame(0, 3, 64'h5A_C3_81, -1, 8'h0, 0, "R8 full last");
      tx_frame(3, 2, 64'h96_3C, 2, 8'h05, 5, "R10 tx midwrite");
      tx_frame(5, 2, 64'hF0_0F, -1, 8'h0, 0, "R10 tx next");

      // random frames
      for (int r = 0; r < 24; r++) begin
         int off = $urandom % 8;
         int nb = $urandom % 31;
         rx_frame(off, nb, {$urandom, $urandom}, -1, 8'h0, 0, "R4 rand");
      end
      for (int r = 0; r < 24; r++) begin
         int len = $urandom % 8;
         int n = 1 + ($urandom % 4);
         tx_frame(len, n, {$urandom, $urandom}, -1, 8'h0, 0, "R7 rand");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule